// File: doc/BRIEF.md
# Nine-Bit Serial Port with Receiver Sleep

This block is a full-duplex asynchronous serial port. The transmitter and receiver share one character-length setting. A character is one start bit (low), then 8 or 9 data bits sent least significant bit first, then one stop bit (high). The port is driven through a small register window. One address is the data register: writes go to the transmitter and reads come from the receiver. A second address is the format register, which holds the ninth bits and the mode selects. A third is the control register, and a fourth holds the status flags. Two request outputs, one for each direction, are formed from the status flags and their enable bits.

Bit timing comes from a fixed clock divider followed by a 16x oversampling tick, so one bit lasts 16*BAUD_DIV clocks. The receiver takes a majority vote of three samples near the middle of each bit.

The receiver can be put to sleep. While it sleeps it discards characters and raises no flags. Depending on the wake-mode bit, it wakes when the line has been idle for a full character time, or when a character arrives whose most significant data bit is set. That character is the address mark, and it is delivered. The transmitter can also hold the line low to send a break.

Top module: `uart9_wake`

## Requirements
- R1: After reset the control register (address 2) reads 0, the format register (address 1) reads 0, the status register (address 3) reads 8'hC0, `txd` is high and both request outputs are low.
- R2: With format bit 4 (nine-bit mode) clear, a value written to address 0 is sent as a 10-bit frame: a low start bit, data bits 0 to 7 in order, then a high stop bit, each bit lasting 16*BAUD_DIV clocks.
- R3: With format bit 4 set, the frame carries 9 data bits, and the ninth is format bit 6 as it stood when the shifter was loaded. On reception in this mode the ninth received bit appears at format bit 7, together with the low 8 bits at address 0.
- R4: A received character sets status bit 5 (receive full), and its low 8 bits read back at address 0. A read of address 0 clears status bits 5 and 4.
- R5: Format bits 7 (ninth received bit), 5, 2, 1 and 0 ignore writes. Bits 2 and 1 always read 0.
- R6: A write to address 0 clears status bit 7 (transmit empty) and bit 6 (transmit complete). Bit 7 sets again when the value moves into the shifter. Bit 6 sets when the shifter finishes and no new value is waiting.
- R7: While control bit 0 (break) is set, `txd` is low from the clock after the write. Once the bit is cleared, `txd` returns high.
- R8: When the line has been high for one full character time (10 or 11 bit times) after a low, status bit 4 (idle) sets, provided the receiver is awake and enabled.
- R9: While control bit 1 (sleep) is set, status bits 5 and 4 do not set. With format bit 3 clear, an idle line clears control bit 1 without setting status bit 4.
- R10: With format bit 3 set, a sleeping receiver discards characters whose most significant data bit is 0 (bit 7 in 8-bit mode, bit 8 in 9-bit mode). A character with that bit set clears control bit 1 and is delivered.
- R11: `irq_tx` = (control bit 7 AND status bit 7) OR (control bit 6 AND status bit 6). `irq_rx` = (control bit 5 AND status bit 5) OR (control bit 4 AND status bit 4).
- R12: With control bit 3 (transmit enable) clear, written data waits and `txd` stays high. With control bit 2 (receive enable) clear, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address: 0 data, 1 format, 2 control, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is a sleeping receiver in address-mark mode. It has to discard a whole character, then also ignore the idle stretch that follows without clearing sleep or setting the idle flag, and finally wake on exactly the character whose top data bit is set. The bench gets there by driving `rxd` frame by frame from a task. It sends a non-address character, then waits more than a character time, then sends an address character. It reads the control and status registers between each step, in both 8-bit and 9-bit modes. Transmit framing and ninth-bit transfer are covered by looping `txd` back to `rxd`. A table of characters is walked, and each serial frame is decoded as well as read back through the receiver.

// File: rtl/uart9_wake.sv
module uart9_wake #(
  parameter int BAUD_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_tx,
  output logic       irq_rx
);

  localparam int OVS    = 16;
  localparam int DIV_W  = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int IDLE_W = $clog2(11 * OVS + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM8 = IDLE_W'(10 * OVS);
  localparam logic [IDLE_W-1:0] IDLE_LIM9 = IDLE_W'(11 * OVS);
  localparam logic [1:0] A_DATA = 2'd0, A_FMT = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

  logic [DIV_W-1:0] div_q;
  logic             tick;

  logic tie, tcie, rie, ilie, te, re, rwu, sbk;
  logic t8, mode9, wake_addr, rx_b8;

  logic wr_data, wr_fmt, wr_ctrl, rd_data;

  logic [10:0] tx_sh;
  logic [7:0]  tdr;
  logic [3:0]  tx_ph, tx_cnt, tx_last;
  logic        tx_busy, tdre, tc;

  logic       rx_s1, rx_s;
  logic       rx_act, s7, s8, vote;
  logic [3:0] rx_ph, rx_bit, rx_last;
  logic [8:0] rx_sh;
  logic [7:0] rdr;
  logic       rdrf, idle_f;
  logic       rx_done, rx_accept, hw_wake;

  logic [IDLE_W-1:0] idle_q, idle_lim;
  logic              idle_evt;

  assign wr_data = wr_en && addr == A_DATA;
  assign wr_fmt  = wr_en && addr == A_FMT;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign rd_data = rd_en && addr == A_DATA;

  assign tick = (div_q == DIV_W'(BAUD_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  assign hw_wake = rwu && ((rx_done && wake_addr && rx_sh[8]) ||
                           (idle_evt && !wake_addr));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {tie, tcie, rie, ilie, te, re, rwu, sbk} <= 8'h00;
    end else if (wr_ctrl) begin
      {tie, tcie, rie, ilie, te, re, rwu, sbk} <= wdata;
    end else if (hw_wake) begin
      rwu <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t8 <= 1'b0; mode9 <= 1'b0; wake_addr <= 1'b0;
    end else if (wr_fmt) begin
      t8 <= wdata[6]; mode9 <= wdata[4]; wake_addr <= wdata[3];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tdr <= 8'h00;
    else if (wr_data) tdr <= wdata;

  assign tx_last = mode9 ? 4'd10 : 4'd9;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_busy <= 1'b0;
      tx_ph   <= '0;
      tx_cnt  <= '0;
      tdre    <= 1'b1;
      tc      <= 1'b1;
    end else begin
      if (!tx_busy) begin
        if (te && !tdre) begin
          tx_sh   <= {1'b1, mode9 ? t8 : 1'b1, tdr, 1'b0};
          tx_busy <= 1'b1;
          tx_ph   <= '0;
          tx_cnt  <= '0;
          tdre    <= 1'b1;
        end
      end else if (tick) begin
        tx_ph <= tx_ph + 1'b1;
        if (tx_ph == 4'd15) begin
          tx_sh <= {1'b1, tx_sh[10:1]};
          if (tx_cnt == tx_last) begin
            tx_busy <= 1'b0;
            tc      <= tdre;
          end else begin
            tx_cnt <= tx_cnt + 1'b1;
          end
        end
      end
      if (wr_data) begin
        tdre <= 1'b0;
        tc   <= 1'b0;
      end
    end

  assign txd = !sbk && (!tx_busy || tx_sh[0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s  <= rx_s1;
    end

  assign vote    = (s7 & s8) | (s7 & rx_s) | (s8 & rx_s);
  assign rx_last = mode9 ? 4'd10 : 4'd9;
  assign rx_done = tick && rx_act && rx_ph == 4'd9 && rx_bit == rx_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_act <= 1'b0;
      rx_ph  <= '0;
      rx_bit <= '0;
      s7     <= 1'b1;
      s8     <= 1'b1;
      rx_sh  <= '0;
    end else if (!re) begin
      rx_act <= 1'b0;
    end else if (tick) begin
      if (!rx_act) begin
        if (!rx_s) begin
          rx_act <= 1'b1;
          rx_ph  <= 4'd1;
          rx_bit <= '0;
        end
      end else begin
        rx_ph <= rx_ph + 1'b1;
        if (rx_ph == 4'd7) s7 <= rx_s;
        if (rx_ph == 4'd8) s8 <= rx_s;
        if (rx_ph == 4'd9) begin
          if (rx_bit == 4'd0) begin
            if (vote) rx_act <= 1'b0;
          end else if (rx_bit == rx_last) begin
            rx_act <= 1'b0;
          end else begin
            rx_sh <= {vote, rx_sh[8:1]};
          end
        end
        if (rx_ph == 4'd15) rx_bit <= rx_bit + 1'b1;
      end
    end

  assign rx_accept = rx_done && (!rwu || (wake_addr && rx_sh[8]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdr   <= 8'h00;
      rx_b8 <= 1'b0;
    end else if (rx_accept) begin
      rdr   <= mode9 ? rx_sh[7:0] : rx_sh[8:1];
      rx_b8 <= mode9 & rx_sh[8];
    end

  assign idle_lim = mode9 ? IDLE_LIM9 : IDLE_LIM8;
  assign idle_evt = tick && re && rx_s && idle_q == idle_lim - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    idle_q <= '1;
    else if (!re)  idle_q <= '1;
    else if (tick) begin
      if (!rx_s)                idle_q <= '0;
      else if (idle_q < idle_lim) idle_q <= idle_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdrf   <= 1'b0;
      idle_f <= 1'b0;
    end else begin
      if (rd_data) begin
        rdrf   <= 1'b0;
        idle_f <= 1'b0;
      end
      if (rx_accept)          rdrf   <= 1'b1;
      if (idle_evt && !rwu)   idle_f <= 1'b1;
    end

  always_comb
    case (addr)
      A_DATA:  rdata = rdr;
      A_FMT:   rdata = {rx_b8, t8, 1'b0, mode9, wake_addr, 3'b000};
      A_CTRL:  rdata = {tie, tcie, rie, ilie, te, re, rwu, sbk};
      default: rdata = {tdre, tc, rdrf, idle_f, 4'b0000};
    endcase

  assign irq_tx = (tie & tdre) | (tcie & tc);
  assign irq_rx = (rie & rdrf) | (ilie & idle_f);

endmodule

// File: rtl/uart9_wake_chk.sv
module uart9_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       wbit0,
  input logic       txd,
  input logic       sbk,
  input logic       tx_busy,
  input logic       tdre,
  input logic       tc,
  input logic       rdrf,
  input logic       rwu,
  input logic       wake_addr,
  input logic       rx_done,
  input logic       idle_evt,
  input logic       rx_b8
);

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_busy) && !sbk) |-> !txd); // R2

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && wbit0) |=> !txd); // R7

  AST_R8_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !rx_done) |=> $stable(rx_b8)); // R5

  AST_TC_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (!tx_busy && tdre)); // R6

  AST_SLEEP_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdrf) |-> (!$past(rwu) || $past(wake_addr))); // R9

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rwu) && !$past(wr_en && addr == 2'd2)) |-> $past(rx_done || idle_evt)); // R10

endmodule

bind uart9_wake uart9_wake_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbit0(wdata[0]),
  .txd(txd), .sbk(sbk), .tx_busy(tx_busy), .tdre(tdre), .tc(tc),
  .rdrf(rdrf), .rwu(rwu), .wake_addr(wake_addr), .rx_done(rx_done),
  .idle_evt(idle_evt), .rx_b8(rx_b8)
);

// File: tb/uart9_wake_tb_top.sv
module uart9_wake_tb_top;

  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;
  localparam int NV  = 5;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h55}, {1'b0, 1'b0, 8'hA3}, {1'b1, 1'b0, 8'hF0},
    {1'b0, 1'b0, 8'h00}, {1'b1, 1'b1, 8'h0F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic txd, irq_tx, irq_rx;
  logic loop = 1'b0, rx_drv = 1'b1;
  wire  rxd = loop ? txd : rx_drv;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  uart9_wake #(.BAUD_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_char(input logic m9, input logic [8:0] v);
    int nb;
    nb = m9 ? 9 : 8;
    rx_drv = 1'b0; wait_clk(BIT);
    for (int i = 0; i < nb; i++) begin rx_drv = v[i]; wait_clk(BIT); end
    rx_drv = 1'b1; wait_clk(BIT);
  endtask

  task automatic grab_frame(input logic m9, output logic [8:0] v, output logic ok);
    int nb;
    nb = m9 ? 9 : 8;
    v = '0;
    @(negedge txd);
    wait_clk(BIT / 2);
    ok = (txd == 1'b0);
    for (int i = 0; i < nb; i++) begin wait_clk(BIT); v[i] = txd; end
    wait_clk(BIT);
    ok = ok && (txd == 1'b1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [8:0] got;
    logic ok;
    int lows;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    cpu_rd(2'd2, rv); chk("R1 control", rv, 8'h00);
    cpu_rd(2'd1, rv); chk("R1 format", rv, 8'h00);
    cpu_rd(2'd3, rv); chk("R1 status", rv, 8'hC0);
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", {irq_tx, irq_rx}, 2'b00);

    cpu_wr(2'd2, 8'h80); chk("R11 tie", irq_tx, 1'b1);
    cpu_wr(2'd2, 8'h40); chk("R11 tcie", irq_tx, 1'b1);
    cpu_wr(2'd2, 8'h00); chk("R11 off", irq_tx, 1'b0);

    loop = 1'b1;
    cpu_wr(2'd2, 8'h0C);
    for (int k = 0; k < NV; k++) begin
      cpu_wr(2'd1, {1'b0, VEC[k][8], 1'b0, VEC[k][9], 4'b0000});
      cpu_wr(2'd0, VEC[k][7:0]);
      grab_frame(VEC[k][9], got, ok);
      chk(VEC[k][9] ? "R3 framing" : "R2 framing", ok, 1'b1);
      chk(VEC[k][9] ? "R3 tx bits" : "R2 tx bits", got,
          VEC[k][9] ? VEC[k][8:0] : {1'b0, VEC[k][7:0]});
      wait_clk(BIT);
      cpu_rd(2'd3, rv); chk("R4 full set", rv[5], 1'b1);
      cpu_rd(2'd1, rv); chk("R3 rx bit8", rv[7], VEC[k][9] & VEC[k][8]);
      cpu_rd(2'd0, rv); chk("R4 rx data", rv, VEC[k][7:0]);
      cpu_rd(2'd3, rv); chk("R4 full clear", rv[5], 1'b0);
    end
    loop = 1'b0;

    cpu_wr(2'd1, 8'hFF);
    cpu_rd(2'd1, rv); chk("R5 format write", rv, 8'hD8);
    cpu_wr(2'd1, 8'h00);
    cpu_rd(2'd1, rv); chk("R5 r8 kept", rv, 8'h80);

    wait_clk(2 * 11 * BIT);
    cpu_rd(2'd0, rv);
    cpu_wr(2'd2, 8'h34);
    drive_char(1'b0, 9'h03C);
    wait_clk(16);
    cpu_rd(2'd3, rv); chk("R4 rx full", rv, 8'hE0);
    chk("R11 rx irq", irq_rx, 1'b1);
    wait_clk(12 * BIT);
    cpu_rd(2'd3, rv); chk("R8 idle set", rv, 8'hF0);
    cpu_rd(2'd0, rv); chk("R4 data", rv, 8'h3C);
    cpu_rd(2'd3, rv); chk("R8 idle clear", rv, 8'hC0);
    chk("R11 rx irq off", irq_rx, 1'b0);

    cpu_wr(2'd2, 8'h06);
    drive_char(1'b0, 9'h041);
    wait_clk(16);
    cpu_rd(2'd3, rv); chk("R9 dropped", rv, 8'hC0);
    cpu_rd(2'd2, rv); chk("R9 still asleep", rv, 8'h06);
    wait_clk(12 * BIT);
    cpu_rd(2'd2, rv); chk("R9 idle wake", rv, 8'h04);
    cpu_rd(2'd3, rv); chk("R9 no idle flag", rv, 8'hC0);
    drive_char(1'b0, 9'h07E);
    wait_clk(16);
    cpu_rd(2'd0, rv); chk("R9 awake data", rv, 8'h7E);

    cpu_wr(2'd1, 8'h08);
    cpu_wr(2'd2, 8'h06);
    drive_char(1'b0, 9'h035);
    wait_clk(12 * BIT);
    cpu_rd(2'd3, rv); chk("R10 non-address dropped", rv, 8'hC0);
    cpu_rd(2'd2, rv); chk("R10 idle ignored", rv, 8'h06);
    drive_char(1'b0, 9'h095);
    wait_clk(16);
    cpu_rd(2'd3, rv); chk("R10 address full", rv, 8'hE0);
    cpu_rd(2'd2, rv); chk("R10 woke", rv, 8'h04);
    cpu_rd(2'd0, rv); chk("R10 address data", rv, 8'h95);

    cpu_wr(2'd1, 8'h18);
    cpu_wr(2'd2, 8'h06);
    drive_char(1'b1, 9'h0FF);
    wait_clk(16);
    cpu_rd(2'd3, rv); chk("R10 nine-bit dropped", rv, 8'hC0);
    drive_char(1'b1, 9'h112);
    wait_clk(16);
    cpu_rd(2'd1, rv); chk("R10 nine-bit mark", rv, 8'h98);
    cpu_rd(2'd0, rv); chk("R10 nine-bit data", rv, 8'h12);

    cpu_wr(2'd1, 8'h00);
    cpu_wr(2'd2, 8'h00);
    drive_char(1'b0, 9'h05A);
    wait_clk(16);
    cpu_rd(2'd3, rv); chk("R12 rx disabled", rv, 8'hC0);

    cpu_wr(2'd0, 8'hC3);
    cpu_rd(2'd3, rv); chk("R6 write clears", rv, 8'h00);
    lows = 0;
    for (int i = 0; i < 12 * BIT; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R12 tx disabled", lows, 0);
    cpu_wr(2'd2, 8'h08);
    wait_clk(4);
    cpu_rd(2'd3, rv); chk("R6 loaded busy", rv, 8'h80);
    wait_clk(12 * BIT);
    cpu_rd(2'd3, rv); chk("R6 complete", rv, 8'hC0);

    cpu_wr(2'd2, 8'h09);
    chk("R7 break low", txd, 1'b0);
    wait_clk(3 * BIT);
    chk("R7 break held", txd, 1'b0);
    cpu_wr(2'd2, 8'h08);
    chk("R7 break released", txd, 1'b1);

    finish_run();
  end

endmodule